// File: doc/BRIEF.md
# Fixed-Block Serial-Port DMA Controller

This block copies a fixed 64-byte block between system DRAM and a small controller-interface memory. Software sets the DRAM start address in one register, then starts a transfer by writing the interface-side address into one of two start registers. The register written picks the direction. A start write sets a busy flag at once. After a fixed latency of `DELAY` cycles the copy runs byte by byte, in ascending address order. When the last byte has been written, busy clears and an interrupt is raised. A write to the status offset acknowledges the interrupt.

A copy toward DRAM is preceded by a one-cycle request pulse on `cmd_run`. This pulse asks the attached peripheral to process its pending commands before its memory is read. Both memories are reached through byte-wide valid/ready request ports. A request stays asserted, with address, write enable and write data unchanged, until the memory raises ready; the memory may hold ready low for any number of cycles. For a read, the memory returns `*_rdata` combinationally in the cycle the handshake completes. Register reads are combinational on `reg_rd_off`.

Top module: `sdma_top`

## Requirements
- R1: After reset, busy and the interrupt are 0, no memory request or `cmd_run` is asserted, and reads at offsets 0x00, 0x04 and 0x18 return 0.
- R2: A write to offset 0x00 stores the low `DRAM_AW` bits (24 by default) of the data as the DRAM start address; a read at 0x00 returns it zero-extended.
- R3: A write to offset 0x04 or 0x10 while idle stores the data masked to 29 bits (0x1FFF_FFFF), readable at 0x04, and sets busy (status bit 0, read at 0x18) from the next cycle.
- R4: The first memory request appears exactly `DELAY` cycles after the start write's clock edge for a 0x10 start, and `DELAY`+1 cycles after it for a 0x04 start.
- R5: A 0x04 start copies interface bytes [I+i] to DRAM bytes [D+i] for i = 0..63, where I is the masked start data and D the DRAM start address. Exactly one single-cycle `cmd_run` pulse appears, in the cycle just before the first interface read.
- R6: A 0x10 start copies DRAM bytes [D+i] to interface bytes [I+i] for i = 0..63, with no `cmd_run` pulse.
- R7: Each memory request holds valid, address, write enable and write data steady until ready. The source side is never written, the destination takes exactly 64 writes, and the two ports never request in the same cycle; the result is the same for any ready pattern.
- R8: In the cycle after the 64th write handshake, busy reads 0 and the interrupt is 1, both on the `irq` pin and in status bit 12.
- R9: A write to offset 0x18 clears the interrupt and leaves busy unchanged.
- R10: A start write at 0x04 or 0x10 while busy is ignored: the interface address read back is unchanged and no extra bytes are moved.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_off | input | 5 | Register write byte offset |
| reg_wr_data | input | 32 | Register write data |
| reg_rd_off | input | 5 | Register read byte offset |
| reg_rd_data | output | 32 | Register read data (combinational) |
| irq | output | 1 | Transfer-complete interrupt |
| cmd_run | output | 1 | One-cycle command-processing request |
| dram_valid | output | 1 | DRAM request valid |
| dram_ready | input | 1 | DRAM request accepted |
| dram_we | output | 1 | DRAM request is a write |
| dram_addr | output | DRAM_AW | DRAM byte address |
| dram_wdata | output | 8 | DRAM write byte |
| dram_rdata | input | 8 | DRAM read byte, valid at handshake |
| ifm_valid | output | 1 | Interface-memory request valid |
| ifm_ready | input | 1 | Interface-memory request accepted |
| ifm_we | output | 1 | Interface-memory request is a write |
| ifm_addr | output | IF_AW | Interface-memory byte address |
| ifm_wdata | output | 8 | Interface-memory write byte |
| ifm_rdata | input | 8 | Interface-memory read byte, valid at handshake |

## Verification
The state in this block shows at the ports quickly. A wrong latency counter moves the first request away from cycle `DELAY` (or `DELAY`+1) and is caught on the first transfer. A wrong direction latch sends writes to the source port and leaves the destination region unchanged, which the per-byte comparison finds within the same transfer. A byte index that skips, repeats or stops early gives a destination write count other than 64, or a wrong byte at a known offset. A busy or interrupt flag that does not follow the handshakes shows in the status word read one cycle after the last write.

// File: rtl/sdma_pkg.sv
package sdma_pkg;
  localparam logic [4:0] OFF_DRAM_BASE = 5'h00;
  localparam logic [4:0] OFF_GO_TO_DRAM = 5'h04;
  localparam logic [4:0] OFF_GO_TO_IFM = 5'h10;
  localparam logic [4:0] OFF_STATUS = 5'h18;

  localparam int XFER_BYTES = 64;
  localparam int IDX_W = $clog2(XFER_BYTES);
  localparam int STAT_BUSY_BIT = 0;
  localparam int STAT_IRQ_BIT = 12;

  typedef enum logic {
    DIR_TO_DRAM = 1'b0,
    DIR_TO_IFM = 1'b1
  } dir_t;

  typedef enum logic [1:0] {
    MV_IDLE = 2'd0,
    MV_CMD = 2'd1,
    MV_RD = 2'd2,
    MV_WR = 2'd3
  } mv_state_t;
endpackage

// File: rtl/sdma_regs.sv
module sdma_regs
  import sdma_pkg::*;
#(
  parameter int DRAM_AW = 24,
  parameter int IF_AW = 29
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [4:0]         wr_off,
  input  logic [31:0]        wr_data,
  input  logic [4:0]         rd_off,
  output logic [31:0]        rd_data,
  input  logic               done,
  output logic               busy,
  output logic               irq,
  output logic               start,
  output dir_t               start_dir,
  output logic [IF_AW-1:0]   start_ifm,
  output logic [DRAM_AW-1:0] dram_base
);
  logic [IF_AW-1:0] ifm_base;
  logic go_wr;
  logic ack_wr;
  logic unused_wr_bits;

  assign go_wr = wr_en && (wr_off == OFF_GO_TO_DRAM || wr_off == OFF_GO_TO_IFM);
  assign ack_wr = wr_en && (wr_off == OFF_STATUS);
  assign start = go_wr && !busy;
  assign start_dir = (wr_off == OFF_GO_TO_DRAM) ? DIR_TO_DRAM : DIR_TO_IFM;
  assign start_ifm = wr_data[IF_AW-1:0];
  assign unused_wr_bits = ^wr_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dram_base <= '0;
      ifm_base <= '0;
      busy <= 1'b0;
      irq <= 1'b0;
    end else begin
      if (wr_en && wr_off == OFF_DRAM_BASE) dram_base <= wr_data[DRAM_AW-1:0];
      if (start) ifm_base <= start_ifm;
      if (start) busy <= 1'b1;
      else if (done) busy <= 1'b0;
      if (done) irq <= 1'b1;
      else if (ack_wr) irq <= 1'b0;
    end
  end

  always_comb begin
    rd_data = '0;
    case (rd_off)
      OFF_DRAM_BASE: rd_data = 32'(dram_base);
      OFF_GO_TO_DRAM: rd_data = 32'(ifm_base);
      OFF_STATUS: begin
        rd_data[STAT_BUSY_BIT] = busy;
        rd_data[STAT_IRQ_BIT] = irq;
      end
      default: rd_data = '0;
    endcase
  end

  // R8
  done_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);
  // R8
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(done));
  // R9
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_wr && !done) |=> !irq);
  // R10
  ignore_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (go_wr && busy) |=> $stable(ifm_base));
endmodule

// File: rtl/sdma_timer.sv
module sdma_timer #(
  parameter int DELAY = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic go
);
  localparam int CW = $clog2(DELAY + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (start) cnt <= CW'(DELAY);
    else if (cnt != '0) cnt <= cnt - 1'b1;
  end

  assign go = (cnt == CW'(1));

  // R4
  go_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> !go);
  // R4
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DELAY));
endmodule

// File: rtl/sdma_mover.sv
module sdma_mover
  import sdma_pkg::*;
#(
  parameter int DRAM_AW = 24,
  parameter int IF_AW = 29
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  dir_t               start_dir,
  input  logic [DRAM_AW-1:0] start_dram,
  input  logic [IF_AW-1:0]   start_ifm,
  input  logic               go,
  output logic               cmd_run,
  output logic               done,
  output dir_t               dir,
  output logic               rd_valid,
  input  logic               rd_ready,
  input  logic [7:0]         rd_data,
  output logic               wr_valid,
  input  logic               wr_ready,
  output logic [7:0]         wr_data,
  output logic [DRAM_AW-1:0] dram_addr,
  output logic [IF_AW-1:0]   ifm_addr
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(XFER_BYTES - 1);

  mv_state_t state;
  logic [IDX_W-1:0] idx;
  logic [DRAM_AW-1:0] dbase;
  logic [IF_AW-1:0] ibase;
  logic [7:0] byte_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= MV_IDLE;
      idx <= '0;
      dbase <= '0;
      ibase <= '0;
      byte_q <= '0;
      dir <= DIR_TO_DRAM;
    end else begin
      if (start) begin
        dir <= start_dir;
        dbase <= start_dram;
        ibase <= start_ifm;
      end
      case (state)
        MV_IDLE: if (go) begin
          idx <= '0;
          state <= (dir == DIR_TO_DRAM) ? MV_CMD : MV_RD;
        end
        MV_CMD: state <= MV_RD;
        MV_RD: if (rd_ready) begin
          byte_q <= rd_data;
          state <= MV_WR;
        end
        MV_WR: if (wr_ready) begin
          if (idx == LAST_IDX) state <= MV_IDLE;
          else begin
            idx <= idx + 1'b1;
            state <= MV_RD;
          end
        end
        default: state <= MV_IDLE;
      endcase
    end
  end

  assign cmd_run = (state == MV_CMD);
  assign rd_valid = (state == MV_RD);
  assign wr_valid = (state == MV_WR);
  assign wr_data = byte_q;
  assign done = wr_valid && wr_ready && (idx == LAST_IDX);
  assign dram_addr = dbase + DRAM_AW'(idx);
  assign ifm_addr = ibase + IF_AW'(idx);

  // R5
  cmd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_run |=> (rd_valid && !cmd_run));
  // R6
  cmd_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_run |-> (dir == DIR_TO_DRAM));
  // R7
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(dram_addr) && $stable(ifm_addr)));
  // R7
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_data) && $stable(dram_addr) && $stable(ifm_addr)));
endmodule

// File: rtl/sdma_portmux.sv
module sdma_portmux
  import sdma_pkg::*;
#(
  parameter int DRAM_AW = 24,
  parameter int IF_AW = 29
) (
  input  logic               clk,
  input  logic               rst_n,
  input  dir_t               dir,
  input  logic               rd_valid,
  output logic               rd_ready,
  output logic [7:0]         rd_data,
  input  logic               wr_valid,
  output logic               wr_ready,
  input  logic [7:0]         wr_data,
  input  logic [DRAM_AW-1:0] dram_addr_in,
  input  logic [IF_AW-1:0]   ifm_addr_in,
  output logic               dram_valid,
  input  logic               dram_ready,
  output logic               dram_we,
  output logic [DRAM_AW-1:0] dram_addr,
  output logic [7:0]         dram_wdata,
  input  logic [7:0]         dram_rdata,
  output logic               ifm_valid,
  input  logic               ifm_ready,
  output logic               ifm_we,
  output logic [IF_AW-1:0]   ifm_addr,
  output logic [7:0]         ifm_wdata,
  input  logic [7:0]         ifm_rdata
);
  logic to_dram;
  assign to_dram = (dir == DIR_TO_DRAM);

  assign dram_valid = to_dram ? wr_valid : rd_valid;
  assign dram_we = to_dram;
  assign dram_addr = dram_addr_in;
  assign dram_wdata = wr_data;

  assign ifm_valid = to_dram ? rd_valid : wr_valid;
  assign ifm_we = !to_dram;
  assign ifm_addr = ifm_addr_in;
  assign ifm_wdata = wr_data;

  assign rd_ready = to_dram ? ifm_ready : dram_ready;
  assign rd_data = to_dram ? ifm_rdata : dram_rdata;
  assign wr_ready = to_dram ? dram_ready : ifm_ready;

  // R7
  one_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(dram_valid && ifm_valid));
endmodule

// File: rtl/sdma_top.sv
module sdma_top
  import sdma_pkg::*;
#(
  parameter int DELAY = 40,
  parameter int DRAM_AW = 24,
  parameter int IF_AW = 29
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr_en,
  input  logic [4:0]         reg_wr_off,
  input  logic [31:0]        reg_wr_data,
  input  logic [4:0]         reg_rd_off,
  output logic [31:0]        reg_rd_data,
  output logic               irq,
  output logic               cmd_run,
  output logic               dram_valid,
  input  logic               dram_ready,
  output logic               dram_we,
  output logic [DRAM_AW-1:0] dram_addr,
  output logic [7:0]         dram_wdata,
  input  logic [7:0]         dram_rdata,
  output logic               ifm_valid,
  input  logic               ifm_ready,
  output logic               ifm_we,
  output logic [IF_AW-1:0]   ifm_addr,
  output logic [7:0]         ifm_wdata,
  input  logic [7:0]         ifm_rdata
);
  logic busy, start, go, done;
  dir_t start_dir, dir;
  logic [IF_AW-1:0] start_ifm, mv_ifm_addr;
  logic [DRAM_AW-1:0] dram_base, mv_dram_addr;
  logic rd_valid, rd_ready, wr_valid, wr_ready;
  logic [7:0] rd_data, wr_data;

  sdma_regs #(.DRAM_AW(DRAM_AW), .IF_AW(IF_AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .wr_off(reg_wr_off),
    .wr_data(reg_wr_data), .rd_off(reg_rd_off), .rd_data(reg_rd_data),
    .done(done), .busy(busy), .irq(irq), .start(start),
    .start_dir(start_dir), .start_ifm(start_ifm), .dram_base(dram_base)
  );

  sdma_timer #(.DELAY(DELAY)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(start), .go(go)
  );

  sdma_mover #(.DRAM_AW(DRAM_AW), .IF_AW(IF_AW)) u_mover (
    .clk(clk), .rst_n(rst_n), .start(start), .start_dir(start_dir),
    .start_dram(dram_base), .start_ifm(start_ifm), .go(go),
    .cmd_run(cmd_run), .done(done), .dir(dir),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .dram_addr(mv_dram_addr), .ifm_addr(mv_ifm_addr)
  );

  sdma_portmux #(.DRAM_AW(DRAM_AW), .IF_AW(IF_AW)) u_mux (
    .clk(clk), .rst_n(rst_n), .dir(dir),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .dram_addr_in(mv_dram_addr), .ifm_addr_in(mv_ifm_addr),
    .dram_valid(dram_valid), .dram_ready(dram_ready), .dram_we(dram_we),
    .dram_addr(dram_addr), .dram_wdata(dram_wdata), .dram_rdata(dram_rdata),
    .ifm_valid(ifm_valid), .ifm_ready(ifm_ready), .ifm_we(ifm_we),
    .ifm_addr(ifm_addr), .ifm_wdata(ifm_wdata), .ifm_rdata(ifm_rdata)
  );

  // R3
  busy_on_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);
  // R7
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !(dram_valid || ifm_valid || cmd_run));
endmodule

// File: tb/tb_sdma_top.sv
`timescale 1ns/1ps
module tb_sdma_top;
  localparam int DLY = 12;
  localparam int DAW = 24;
  localparam int IAW = 29;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr_en = 1'b0;
  logic [4:0] reg_wr_off = '0;
  logic [31:0] reg_wr_data = '0;
  logic [4:0] reg_rd_off = '0;
  logic [31:0] reg_rd_data;
  logic irq, cmd_run;
  logic dram_valid, dram_we, ifm_valid, ifm_we;
  logic dram_ready = 1'b1;
  logic ifm_ready = 1'b1;
  logic [DAW-1:0] dram_addr;
  logic [IAW-1:0] ifm_addr;
  logic [7:0] dram_wdata, dram_rdata, ifm_wdata, ifm_rdata;

  int vectors = 0;
  int fails = 0;
  int seed = 0;
  int xfer_id = 0;
  bit stall = 1'b0;
  int cyc = 0;
  int cmd_cnt = 0, dram_wr_cnt = 0, ifm_wr_cnt = 0;
  int dram_tag[0:1023];
  int ifm_tag[0:1023];
  logic [7:0] dram_val[0:1023];
  logic [7:0] ifm_val[0:1023];

  always #10 clk = ~clk;

  sdma_top #(.DELAY(DLY), .DRAM_AW(DAW), .IF_AW(IAW)) dut (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wr_off(reg_wr_off),
    .reg_wr_data(reg_wr_data), .reg_rd_off(reg_rd_off), .reg_rd_data(reg_rd_data),
    .irq(irq), .cmd_run(cmd_run),
    .dram_valid(dram_valid), .dram_ready(dram_ready), .dram_we(dram_we),
    .dram_addr(dram_addr), .dram_wdata(dram_wdata), .dram_rdata(dram_rdata),
    .ifm_valid(ifm_valid), .ifm_ready(ifm_ready), .ifm_we(ifm_we),
    .ifm_addr(ifm_addr), .ifm_wdata(ifm_wdata), .ifm_rdata(ifm_rdata)
  );

  function automatic logic [7:0] pat(input bit side, input logic [9:0] a, input int s);
    int v;
    v = side ? (a * 13 + 90 + s * 7) : (a * 7 + 3 + s * 31);
    return v[7:0] ^ {a[9:8], 6'b0};
  endfunction

  assign dram_rdata = pat(1'b0, dram_addr[9:0], seed);
  assign ifm_rdata = pat(1'b1, ifm_addr[9:0], seed);

  always @(negedge clk) begin
    cyc <= cyc + 1;
    dram_ready <= !stall || ((cyc % 3) != 1);
    ifm_ready <= !stall || ((cyc % 4) != 2);
  end

  always @(posedge clk) begin
    if (cmd_run) cmd_cnt <= cmd_cnt + 1;
    if (dram_valid && dram_ready && dram_we) begin
      dram_wr_cnt <= dram_wr_cnt + 1;
      dram_tag[dram_addr[9:0]] <= xfer_id;
      dram_val[dram_addr[9:0]] <= dram_wdata;
    end
    if (ifm_valid && ifm_ready && ifm_we) begin
      ifm_wr_cnt <= ifm_wr_cnt + 1;
      ifm_tag[ifm_addr[9:0]] <= xfer_id;
      ifm_val[ifm_addr[9:0]] <= ifm_wdata;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [4:0] off, input logic [31:0] data);
    reg_wr_en = 1'b1;
    reg_wr_off = off;
    reg_wr_data = data;
    @(posedge clk);
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  function automatic logic [31:0] rd(input logic [4:0] off);
    reg_rd_off = off;
    return 32'h0;
  endfunction

  task automatic reg_rd(input logic [4:0] off, output logic [31:0] v);
    reg_rd_off = off;
    #1;
    v = reg_rd_data;
  endtask

  task automatic run_xfer(input bit to_ifm, input int dbase, input int ibase,
                          input bit stl, input bit poke);
    logic [31:0] v;
    int lat, exp_lat, bad, first_bad, dst_w, src_w, wait_n;
    logic [7:0] got, exp;
    stall = stl;
    xfer_id++;
    seed = xfer_id;
    cmd_cnt = 0;
    dram_wr_cnt = 0;
    ifm_wr_cnt = 0;
    reg_wr(5'h00, 32'(dbase));
    reg_wr(to_ifm ? 5'h10 : 5'h04, 32'hE000_0000 | 32'(ibase));
    reg_rd(5'h18, v);
    chk(v[0] == 1'b1, "R3 busy after start", v, 1);
    reg_rd(5'h04, v);
    chk(v == 32'(ibase), "R3 masked interface address", v, ibase);
    lat = 0;
    do begin
      @(posedge clk);
      lat++;
      @(negedge clk);
    end while (!(dram_valid || ifm_valid) && lat < 500);
    exp_lat = to_ifm ? DLY : DLY + 1;
    chk(lat == exp_lat, to_ifm ? "R4 latency dram-to-ifm" : "R4 latency ifm-to-dram", lat, exp_lat);
    if (poke) begin
      reg_wr(to_ifm ? 5'h04 : 5'h10, 32'h0000_0333);
      reg_rd(5'h04, v);
      chk(v == 32'(ibase), "R10 start while busy ignored", v, ibase);
      reg_rd(5'h18, v);
      chk(v[0] == 1'b1, "R10 busy kept", v, 1);
    end
    wait_n = 0;
    do begin
      @(negedge clk);
      reg_rd(5'h18, v);
      wait_n++;
    end while (v[0] && wait_n < 2000);
    chk(v == 32'h0000_1000, "R8 status after completion", v, 32'h1000);
    chk(irq == 1'b1, "R8 irq pin", irq, 1);
    // dest checks
    bad = 0;
    first_bad = -1;
    for (int i = 0; i < 64; i++) begin
      if (to_ifm) begin
        got = ifm_val[ibase + i];
        exp = pat(1'b0, 10'(dbase + i), seed);
        if (ifm_tag[ibase + i] != xfer_id || got !== exp) begin
          bad++;
          if (first_bad < 0) first_bad = i;
        end
      end else begin
        got = dram_val[dbase + i];
        exp = pat(1'b1, 10'(ibase + i), seed);
        if (dram_tag[dbase + i] != xfer_id || got !== exp) begin
          bad++;
          if (first_bad < 0) first_bad = i;
        end
      end
    end
    chk(bad == 0, to_ifm ? "R6 dram-to-ifm data" : "R5 ifm-to-dram data", bad, 0);
    if (to_ifm)
      chk(ifm_tag[ibase - 1] != xfer_id && ifm_tag[ibase + 64] != xfer_id,
          "R6 neighbours untouched", first_bad, -1);
    else
      chk(dram_tag[dbase - 1] != xfer_id && dram_tag[dbase + 64] != xfer_id,
          "R5 neighbours untouched", first_bad, -1);
    dst_w = to_ifm ? ifm_wr_cnt : dram_wr_cnt;
    src_w = to_ifm ? dram_wr_cnt : ifm_wr_cnt;
    chk(dst_w == 64 && src_w == 0, "R7 write counts", dst_w * 1000 + src_w, 64000);
    chk(cmd_cnt == (to_ifm ? 0 : 1), to_ifm ? "R6 no command pulse" : "R5 one command pulse",
        cmd_cnt, to_ifm ? 0 : 1);
    reg_wr(5'h18, 32'h0);
    reg_rd(5'h18, v);
    chk(v == 32'h0 && irq == 1'b0, "R9 acknowledge clears irq", v, 0);
  endtask

  bit finished = 1'b0;

  initial begin
    #(20 * 150000);
    if (!finished) begin
      vectors++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    for (int i = 0; i < 1024; i++) begin
      dram_tag[i] = 0;
      ifm_tag[i] = 0;
    end
    repeat (3) @(negedge clk);
    reg_rd(5'h18, v);
    chk(v == 32'h0, "R1 status after reset", v, 0);
    chk(irq == 1'b0 && cmd_run == 1'b0 && !dram_valid && !ifm_valid, "R1 outputs idle",
        {irq, cmd_run, dram_valid, ifm_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    reg_rd(5'h00, v);
    chk(v == 32'h0, "R1 dram address reset", v, 0);
    reg_rd(5'h04, v);
    chk(v == 32'h0, "R1 interface address reset", v, 0);
    reg_rd(5'h18, v);
    chk(v == 32'h0, "R1 status idle", v, 0);

    for (int k = 0; k < 6; k++) begin
      logic [31:0] d;
      d = 32'h1357_9BDF * (k + 1) ^ (32'hFFFF_FFFF >> (k * 5));
      reg_wr(5'h00, d);
      reg_rd(5'h00, v);
      chk(v == (d & 32'h00FF_FFFF), "R2 dram address register", v, d & 32'h00FF_FFFF);
    end

    reg_wr(5'h18, 32'h0);
    reg_rd(5'h18, v);
    chk(v == 32'h0, "R9 acknowledge while idle keeps busy low", v, 0);

    for (int d = 0; d < 2; d++)
      for (int k = 0; k < 3; k++)
        for (int s = 0; s < 2; s++)
          run_xfer(d[0], 16 + k * 200 + d * 3, 40 + k * 250 + s * 5, s[0],
                   (k == 1 && s == 1));

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule